// File: doc/BRIEF.md
# Time-Division Cluster Slot Scheduler

This block lets a set of simulated node clusters (each of up to 16 nodes) share one physical fabric by handing the fabric to exactly one cluster per time slot. Clusters take turns in ascending index order, wrapping around. At each slot boundary the scheduler saves the context of the cluster that is leaving into an internal context store and fetches the context of the cluster that is arriving, so that the fabric resumes that cluster exactly where it stopped. Only traffic inside a cluster is resolved during its slot. Traffic between clusters is held in separate, non-multiplexed queues outside this block.

Each cluster reports a summary of its downstream flit-queue occupancy, taken from the same traffic-load tables that the routing updater keeps. A cluster with zero pending intra-cluster traffic is idle. It is skipped, and its slot goes to the next cluster that has work. If every cluster is idle, the fabric stays parked on the current cluster and the slot is flagged as not valid.

The whole block runs on the state-handler clock, which runs at twice the system rate. An internal phase bit marks the fast edges that coincide with system-clock edges. A context switch, made of one save write and one restore read with a one-cycle read latency, completes inside a single system-clock period.

Top module: `tdm_slot_sched`

## Requirements
- R1: While reset is held low and on the first fast cycle after it, `active_idx` is 0 and `slot_valid` is 0. `ctx_restore_valid` is 0 and `ctx_restore_data` is 0. Every context-store entry is cleared to 0.
- R2: Slot boundaries fall on fast-clock edges 2*SLOT_LEN, 4*SLOT_LEN, ... counted from the first rising edge with reset high (edge 1). `active_idx` and `slot_valid` change only on a boundary edge.
- R3: A cluster is busy when its OCC_W-bit field `occ_in[i*OCC_W +: OCC_W]` is nonzero, and idle when it is zero. The block samples this on the boundary edge. A cluster that is idle at a boundary is never granted that slot.
- R4: At a boundary the next active cluster is the first busy one in the order active+1, active+2, ..., wrapping modulo NCLUS, with the current cluster considered last. `slot_valid` then becomes 1.
- R5: If no cluster is busy at a boundary, `active_idx` keeps its value and `slot_valid` becomes 0.
- R6: An idle cluster whose occupancy field is nonzero at a boundary is eligible at that same boundary. It keeps no memory of having been idle.
- R7: When the grant moves to a different cluster, the value on `ctx_save_data` at the boundary edge is written into the context entry of the outgoing cluster.
- R8: When the grant moves to a different cluster, `ctx_restore_valid` is 1 for exactly one fast cycle, the one after the boundary edge. During that cycle `ctx_restore_data` carries the stored context of the incoming cluster. When the grant stays on the same cluster, no restore pulse occurs.
- R9: A cluster that stays busy at every boundary is granted within NCLUS boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | State-handler clock, twice the system rate |
| rst_n | input | 1 | Synchronous active-low reset |
| occ_in | input | NCLUS*OCC_W | Per-cluster pending intra-cluster flit count, cluster i at bits i*OCC_W +: OCC_W |
| ctx_save_data | input | CTX_W | Live context of the active cluster, captured at a switching boundary |
| active_idx | output | $clog2(NCLUS) | Index of the cluster mapped onto the fabric |
| slot_valid | output | 1 | Current slot serves a busy cluster |
| ctx_restore_data | output | CTX_W | Context fetched for the incoming cluster |
| ctx_restore_valid | output | 1 | One-cycle strobe qualifying `ctx_restore_data` |

## Verification
The assertions take for granted that `occ_in` and `ctx_save_data` are stable around each rising edge of `clk2x`. They also assume that a boundary never coincides with the restore fetch, which holds for any SLOT_LEN of 1 or more. The bench changes every input only on the falling edge. Its stimulus starts with directed runs: all clusters idle, a single busy cluster, and all clusters busy. It then moves to per-cycle random occupancy in which each cluster's field is zero about half the time, so that skips, wraps, parked slots and re-eligibility all occur.

// File: rtl/tdm_sched_pkg.sv
// Shared types for the time-division cluster scheduler.
// Assumes nothing beyond being compiled before its users.
package tdm_sched_pkg;

    // Fetch sequencer state of the context store.
    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_BUSY = 1'b1
    } fetch_state_e;

endpackage

// File: rtl/tdm_phase_gen.sv
// Phase and slot timing in the double-rate state-handler domain.
// A phase bit toggles on every fast edge. A fast edge taken while the phase
// is 1 coincides with a system-clock edge. Slots last SLOT_LEN system cycles.
// Assumes SLOT_LEN >= 1.
module tdm_phase_gen #(
    parameter int SLOT_LEN = 4
) (
    input  logic clk2x,
    input  logic rst_n,
    output logic boundary
);
    localparam int CNT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

    logic             phase_q;
    logic [CNT_W-1:0] tick_cnt_q;

    // Phase bit: marks the fast edges aligned with system edges.
    always_ff @(posedge clk2x) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Count system ticks within a slot, wrapping at SLOT_LEN.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (phase_q) begin
            if (tick_cnt_q == CNT_W'(SLOT_LEN - 1)) tick_cnt_q <= '0;
            else                                    tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // Boundary on the last system tick of a slot.
    assign boundary = phase_q && (tick_cnt_q == CNT_W'(SLOT_LEN - 1));

    // R2: two boundaries are never on adjacent fast edges.
    a_r2_boundary_spacing: assert property (@(posedge clk2x) disable iff (!rst_n)
        boundary |=> !boundary);

endmodule

// File: rtl/tdm_rr_pick.sv
// Round-robin selector: the first eligible index after cur, wrapping, with
// cur itself tried last. found is 0 when no index is eligible. Purely
// combinational. Assumes NCLUS >= 2.
module tdm_rr_pick #(
    parameter int NCLUS = 6,
    localparam int IDX_W = $clog2(NCLUS)
) (
    input  logic [NCLUS-1:0] elig,
    input  logic [IDX_W-1:0] cur,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    // Scan downward so the smallest forward distance wins.
    always_comb begin
        found = 1'b0;
        pick  = cur;
        for (int d = NCLUS; d >= 1; d--) begin
            int c;
            c = (int'(cur) + d) % NCLUS;
            if (elig[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
        // R3: whatever is picked must be eligible.
        a_r3_pick_eligible: assert (!found || elig[pick]);
    end

endmodule

// File: rtl/tdm_ctx_store.sv
// Per-cluster context register array. A write lands on the request edge.
// A read address is captured on the request edge and the data appears one
// fast cycle later, with a one-cycle valid strobe. Assumes a read and a
// write in the same cycle target different entries.
module tdm_ctx_store
    import tdm_sched_pkg::*;
#(
    parameter int NCLUS = 6,
    parameter int CTX_W = 16,
    localparam int IDX_W = $clog2(NCLUS)
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CTX_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CTX_W-1:0] rd_data,
    output logic             rd_valid
);
    logic [CTX_W-1:0] mem_q [NCLUS];
    logic [IDX_W-1:0] rd_addr_q;
    fetch_state_e     fetch_q;

    // Context array: cleared on reset, written on save.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            for (int i = 0; i < NCLUS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Fetch sequencer: capture the address, then deliver data one cycle later.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            fetch_q   <= FETCH_IDLE;
            rd_addr_q <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= (fetch_q == FETCH_BUSY);
            if (fetch_q == FETCH_BUSY) rd_data <= mem_q[rd_addr_q];
            if (rd_en) begin
                fetch_q   <= FETCH_BUSY;
                rd_addr_q <= rd_addr;
            end else begin
                fetch_q   <= FETCH_IDLE;
            end
        end
    end

    // R7: the save and the fetch of one switch never hit the same entry.
    a_r7_distinct_entries: assert property (@(posedge clk2x) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_addr != rd_addr));

endmodule

// File: rtl/tdm_slot_sched.sv
// Time-division slot scheduler for simulated node clusters on one fabric.
// It derives busy flags from the occupancy summaries, picks the next busy
// cluster round-robin at each slot boundary, parks with slot_valid low when
// all clusters are idle, and runs a save/restore context switch that
// finishes within one system period. Assumes inputs change away from clk2x
// rising edges, with NCLUS >= 2 and SLOT_LEN >= 1.
module tdm_slot_sched
    import tdm_sched_pkg::*;
#(
    parameter int NCLUS    = 6,
    parameter int OCC_W    = 4,
    parameter int CTX_W    = 16,
    parameter int SLOT_LEN = 4,
    localparam int IDX_W   = $clog2(NCLUS)
) (
    input  logic                   clk2x,
    input  logic                   rst_n,
    input  logic [NCLUS*OCC_W-1:0] occ_in,
    input  logic [CTX_W-1:0]       ctx_save_data,
    output logic [IDX_W-1:0]       active_idx,
    output logic                   slot_valid,
    output logic [CTX_W-1:0]       ctx_restore_data,
    output logic                   ctx_restore_valid
);
    logic [NCLUS-1:0] busy_vec;
    logic             boundary;
    logic             any_busy;
    logic [IDX_W-1:0] next_idx;
    logic             do_switch;

    // Per-cluster busy flag: any pending intra-cluster flit.
    for (genvar g = 0; g < NCLUS; g++) begin : g_busy
        assign busy_vec[g] = |occ_in[g*OCC_W +: OCC_W];
    end

    tdm_phase_gen #(.SLOT_LEN(SLOT_LEN)) u_phase (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .boundary (boundary)
    );

    tdm_rr_pick #(.NCLUS(NCLUS)) u_pick (
        .elig  (busy_vec),
        .cur   (active_idx),
        .found (any_busy),
        .pick  (next_idx)
    );

    // Switch only when the grant actually moves.
    assign do_switch = boundary && any_busy && (next_idx != active_idx);

    tdm_ctx_store #(.NCLUS(NCLUS), .CTX_W(CTX_W)) u_store (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .wr_en    (do_switch),
        .wr_addr  (active_idx),
        .wr_data  (ctx_save_data),
        .rd_en    (do_switch),
        .rd_addr  (next_idx),
        .rd_data  (ctx_restore_data),
        .rd_valid (ctx_restore_valid)
    );

    // Grant register: update the active cluster and validity at boundaries.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            active_idx <= '0;
            slot_valid <= 1'b0;
        end else if (boundary) begin
            slot_valid <= any_busy;
            if (any_busy) active_idx <= next_idx;
        end
    end

    // R2: the grant holds between boundaries.
    a_r2_hold_between: assert property (@(posedge clk2x) disable iff (!rst_n)
        !boundary |=> ($stable(active_idx) && $stable(slot_valid)));

    // R3: a valid slot always belongs to a cluster that was busy at the boundary.
    a_r3_idle_never_granted: assert property (@(posedge clk2x) disable iff (!rst_n)
        boundary |=> (!slot_valid ||
                      ((($past(busy_vec) >> active_idx) & NCLUS'(1)) != '0)));

    // R5: with every cluster idle the grant parks and the slot is invalid.
    a_r5_all_idle_park: assert property (@(posedge clk2x) disable iff (!rst_n)
        (boundary && (busy_vec == '0)) |=> (!slot_valid && $stable(active_idx)));

    // R8: a restore strobe follows a boundary by one cycle, and only on a move.
    a_r8_restore_after_move: assert property (@(posedge clk2x) disable iff (!rst_n)
        ctx_restore_valid |-> ($past(boundary, 2) &&
                               ($past(active_idx, 2) != $past(active_idx, 1))));

endmodule

// File: tb/tdm_slot_sched_bench.sv
`timescale 1ns/100ps
module tdm_slot_sched_bench;
    localparam int NCLUS    = 6;
    localparam int OCC_W    = 4;
    localparam int CTX_W    = 16;
    localparam int SLOT_LEN = 4;
    localparam int IDX_W    = $clog2(NCLUS);
    localparam int PERIOD   = 2 * SLOT_LEN;
    localparam int NSLOTS   = 420;

    logic                   clk2x = 1'b0;
    logic                   rst_n;
    logic [NCLUS*OCC_W-1:0] occ_in;
    logic [CTX_W-1:0]       ctx_save_data;
    logic [IDX_W-1:0]       active_idx;
    logic                   slot_valid;
    logic [CTX_W-1:0]       ctx_restore_data;
    logic                   ctx_restore_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // 200 MHz state-handler clock.
    always #2.5 clk2x = ~clk2x;

    tdm_slot_sched #(.NCLUS(NCLUS), .OCC_W(OCC_W), .CTX_W(CTX_W),
                     .SLOT_LEN(SLOT_LEN)) u_tdm_slot_sched (
        .clk2x             (clk2x),
        .rst_n             (rst_n),
        .occ_in            (occ_in),
        .ctx_save_data     (ctx_save_data),
        .active_idx        (active_idx),
        .slot_valid        (slot_valid),
        .ctx_restore_data  (ctx_restore_data),
        .ctx_restore_valid (ctx_restore_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected next cluster per R4/R5: -1 when nothing is busy.
    function automatic int rr_expect(int cur, logic [NCLUS-1:0] busy);
        for (int d = 1; d <= NCLUS; d++) begin
            if (busy[(cur + d) % NCLUS]) return (cur + d) % NCLUS;
        end
        return -1;
    endfunction

    function automatic logic [NCLUS-1:0] busy_of(logic [NCLUS*OCC_W-1:0] o);
        logic [NCLUS-1:0] b;
        for (int i = 0; i < NCLUS; i++) b[i] = |o[i*OCC_W +: OCC_W];
        return b;
    endfunction

    // Occupancy pattern for a given upcoming boundary number.
    function automatic logic [NCLUS*OCC_W-1:0] pattern(int s);
        logic [NCLUS*OCC_W-1:0] o;
        o = '0;
        if (s <= 3) begin
            o = '0;
        end else if (s <= 6) begin
            o[3*OCC_W +: OCC_W] = 4'h8;
        end else if (s <= 16) begin
            for (int i = 0; i < NCLUS; i++) o[i*OCC_W +: OCC_W] = OCC_W'(i + 1);
        end else if (s <= 19) begin
            o[0*OCC_W +: OCC_W] = 4'h1;
            o[5*OCC_W +: OCC_W] = 4'h2;
        end else begin
            if ($urandom % 8 != 0) begin
                for (int i = 0; i < NCLUS; i++)
                    if ($urandom % 2 == 1) o[i*OCC_W +: OCC_W] = OCC_W'(($urandom % 15) + 1);
            end
        end
        return o;
    endfunction

    initial begin
        logic [CTX_W-1:0] mem [NCLUS];
        logic [NCLUS-1:0] busy;
        int exp_act, exp_valid, nxt, k;
        int waits [NCLUS];
        bit pend, exp_rv;
        logic [CTX_W-1:0] exp_rd, pend_rd;
        int seed_dummy;

        seed_dummy = $urandom(32'h5EED);
        for (int i = 0; i < NCLUS; i++) begin mem[i] = '0; waits[i] = 0; end
        exp_act = 0; exp_valid = 0; pend = 0; exp_rv = 0; exp_rd = '0; pend_rd = '0;
        rst_n = 1'b0;
        occ_in = '1;
        ctx_save_data = 16'hABCD;
        repeat (4) @(posedge clk2x);
        @(negedge clk2x);
        check("R1 active_idx in reset", 32'(active_idx), 0);
        check("R1 slot_valid in reset", 32'(slot_valid), 0);
        check("R1 restore_valid in reset", 32'(ctx_restore_valid), 0);
        check("R1 restore_data in reset", 32'(ctx_restore_data), 0);
        rst_n = 1'b1;
        k = 0;
        for (int cyc = 0; cyc < NSLOTS * PERIOD; cyc++) begin
            occ_in = pattern(k / PERIOD + 1);
            ctx_save_data = CTX_W'($urandom);
            @(posedge clk2x);
            k++;
            exp_rv = pend;
            if (pend) exp_rd = pend_rd;
            pend = 0;
            if (k % PERIOD == 0) begin
                busy = busy_of(occ_in);
                nxt = rr_expect(exp_act, busy);
                if (nxt < 0) begin
                    exp_valid = 0;
                end else begin
                    // R9: a busy cluster waits at most NCLUS-1 boundaries.
                    for (int i = 0; i < NCLUS; i++) begin
                        if (busy[i] && i != nxt) waits[i]++;
                        else waits[i] = 0;
                        if (waits[i] >= NCLUS) check("R9 starvation bound", 32'(waits[i]), NCLUS - 1);
                    end
                    if (nxt != exp_act) begin
                        mem[exp_act] = ctx_save_data;
                        pend = 1;
                        pend_rd = mem[nxt];
                    end
                    exp_act = nxt;
                    exp_valid = 1;
                end
                if (nxt < 0) for (int i = 0; i < NCLUS; i++) waits[i] = 0;
            end
            @(negedge clk2x);
            if (k % PERIOD == 0) begin
                check("R4 active_idx at boundary", 32'(active_idx), 32'(exp_act));
                check("R5 slot_valid at boundary", 32'(slot_valid), 32'(exp_valid));
                // R3 and R6: a granted cluster was busy at this boundary.
                if (slot_valid) check("R3 granted cluster busy", 32'(busy[active_idx]), 1);
            end else begin
                check("R2 active_idx held", 32'(active_idx), 32'(exp_act));
                check("R2 slot_valid held", 32'(slot_valid), 32'(exp_valid));
            end
            check("R8 restore strobe", 32'(ctx_restore_valid), 32'(exp_rv));
            if (exp_rv) check("R7 R8 restored context", 32'(ctx_restore_data), 32'(exp_rd));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule